// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two signals of an incremental encoder into a position count. The raw A and B lines are first brought into the system clock domain. An edge decoder then turns their transitions into single up or down steps. The steps move a 32-bit counter that runs between 0 and a programmable ceiling and wraps at either end.

One of four input interpretations can be chosen:

- Full quadrature, where every edge of either line counts and the phase order gives the sign.
- Pulse with a direction level.
- A-only counting up.
- A-only counting down.

The two A-only modes count either on rising edges alone or on both edges of A.

Wrap events set sticky overflow and underflow flags. A flag that is enabled raises a global flag and an interrupt line. Both stay up until software writes ones to a clear register. Software reaches every setting through a small register port, with synchronous writes and a combinational read.

Top module: `qenc_poscnt`

## Requirements
- R1: After reset the position reads 0, the ceiling reads 0xFFFFFFFF, decoder control, main control, interrupt enable and flags read 0, and `irq_o` is low.
- R2: With source field 0 (bits 15:14 of the decoder control register, word address 2), every edge of A or B counts one step. The order AB = 00, 10, 11, 01, 00 counts up and the reverse order counts down.
- R3: In quadrature mode, a transition in which A and B change in the same sampled cycle does not move the count.
- R4: With source field 1, only a rising edge of A counts: up when B is high and down when B is low. Falling edges of A and any edge of B leave the count unchanged.
- R5: With source field 2 the count goes up, and with source field 3 it goes down, on edges of A only. Decoder control bit 11 at 0 counts rising edges only, and at 1 counts both edges. B has no effect in these modes.
- R6: While bit 3 of the main control register (word address 3) is 0, input edges leave the count unchanged.
- R7: A step up from a count at or above the ceiling gives 0 and sets the overflow flag, bit 6 of the flag register (word address 5).
- R8: A step down from 0 gives the ceiling value and sets the underflow flag, bit 5 of the flag register.
- R9: The position (word address 0) and ceiling (word address 1) are readable and writable. A position write appears on the next cycle and takes precedence over a step in that same cycle.
- R10: Flags stay set until a 1 is written to the matching bit of the write-only clear register (word address 6). If a flag's event and its clear fall in the same cycle, the flag stays set.
- R11: When a flag is set and its bit in the interrupt enable register (word address 4, bits 6 and 5) is set, the global flag (flag bit 0) and `irq_o` are raised. They fall only when clear bit 0 is written. Flags that are not enabled never raise them.
- R12: A change on an encoder input moves the count on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Interrupt, equal to the global flag |

## Verification
An input change needs two synchronizer flops and the edge register before the counter takes it, so the count is due on the third rising edge. The bench samples one falling edge before that point and one falling edge after it to pin the latency. Register writes, flags and the interrupt line settle on the first rising edge after the write strobe. Every read is therefore taken on the falling edge that follows. The same-cycle collision cases depend on that fixed latency: a clear or position write is timed to land on the exact edge where a step from an earlier input change arrives.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef enum logic [1:0] {
      SRC_QUAD = 2'd0,
      SRC_PDIR = 2'd1,
      SRC_UP   = 2'd2,
      SRC_DOWN = 2'd3
   } src_e;

   // register word addresses
   localparam int A_POS  = 0;
   localparam int A_CEIL = 1;
   localparam int A_DEC  = 2;
   localparam int A_MAIN = 3;
   localparam int A_IE   = 4;
   localparam int A_FLAG = 5;
   localparam int A_CLR  = 6;

   // bit positions software depends on
   localparam int B_SRC_HI = 15;
   localparam int B_SRC_LO = 14;
   localparam int B_BOTH   = 11;
   localparam int B_RUN    = 3;
   localparam int B_OVF    = 6;
   localparam int B_UNF    = 5;
   localparam int B_GLB    = 0;

   // internal flag vector indices
   localparam int F_UNF = 0;
   localparam int F_OVF = 1;
   localparam int N_FLAG = 2;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qenc_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
   import qenc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic a_s,
   input  logic b_s,
   input  src_e src,
   input  logic both_edge,
   output logic step_up,
   output logic step_dn
);

   logic a_prev, b_prev;
   logic a_chg, b_chg, a_rise, a_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
      end else begin
         a_prev <= a_s;
         b_prev <= b_s;
      end
   end

   assign a_chg  = a_s ^ a_prev;
   assign b_chg  = b_s ^ b_prev;
   assign a_rise = a_s & ~a_prev;
   assign a_hit  = both_edge ? a_chg : a_rise;

   always_comb begin
      step_up = 1'b0;
      step_dn = 1'b0;
      unique case (src)
         SRC_QUAD: begin
            // exactly one line moved; a joint change is dropped
            if (a_chg ^ b_chg) begin
               if (a_s ^ b_prev) step_up = 1'b1;
               else              step_dn = 1'b1;
            end
         end
         SRC_PDIR: begin
            if (a_rise) begin
               if (b_s) step_up = 1'b1;
               else     step_dn = 1'b1;
            end
         end
         SRC_UP:   step_up = a_hit;
         SRC_DOWN: step_dn = a_hit;
         default: ;
      endcase
   end

endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] ceil,
   output logic [CNT_W-1:0] pos,
   output logic             ovf_evt,
   output logic             unf_evt
);

   logic [CNT_W-1:0] nxt;

   always_comb begin
      nxt     = pos;
      ovf_evt = 1'b0;
      unf_evt = 1'b0;
      if (ld) begin
         nxt = ld_val;
      end else if (run && step_up) begin
         if (pos >= ceil) begin
            nxt     = '0;
            ovf_evt = 1'b1;
         end else begin
            nxt = pos + CNT_W'(1);
         end
      end else if (run && step_dn) begin
         if (pos == '0) begin
            nxt     = ceil;
            unf_evt = 1'b1;
         end else begin
            nxt = pos - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= nxt;
   end

endmodule

// File: rtl/qenc_flags.sv
module qenc_flags #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   input  logic [NF-1:0] ie,
   input  logic          clr_glb,
   output logic [NF-1:0] flags,
   output logic          glob
);

   logic [NF-1:0] nxt;

   for (genvar g = 0; g < NF; g++) begin : g_flag
      // event beats clear in the same cycle
      assign nxt[g] = (flags[g] & ~clr[g]) | set[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[g] <= 1'b0;
         else        flags[g] <= nxt[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) glob <= 1'b0;
      else        glob <= (glob & ~clr_glb) | (|(nxt & ie));
   end

endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int CTL_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              irq_o
);

   if (CTL_W < 16) begin : g_bad_ctl
      $error("qenc_poscnt: CTL_W must be at least 16");
   end
   if (CNT_W < CTL_W) begin : g_bad_cnt
      $error("qenc_poscnt: CNT_W must be at least CTL_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("qenc_poscnt: ADDR_W must be at least 3");
   end

   logic [1:0]       ab_s;
   logic             step_up, step_dn;
   logic [CNT_W-1:0] pos_q, ceil_q;
   src_e             src_q;
   logic             both_q, cnt_en;
   logic [N_FLAG-1:0] ie_q, flag_q, flag_set, flag_clr;
   logic             glob;
   logic             ovf_evt, unf_evt;
   logic             ld_pos, clr_glb, clr_ovf;
   logic             ovf_flag, unf_flag, ovf_ie;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int w);
      return a == ADDR_W'(w);
   endfunction

   qenc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({enc_b, enc_a}), .q(ab_s)
   );

   qenc_decode u_dec (
      .clk(clk), .rst_n(rst_n), .a_s(ab_s[0]), .b_s(ab_s[1]),
      .src(src_q), .both_edge(both_q),
      .step_up(step_up), .step_dn(step_dn)
   );

   assign ld_pos = reg_we && hit(reg_addr, A_POS);

   qenc_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(cnt_en),
      .step_up(step_up), .step_dn(step_dn),
      .ld(ld_pos), .ld_val(reg_wdata), .ceil(ceil_q),
      .pos(pos_q), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ceil_q <= '1;
         src_q  <= SRC_QUAD;
         both_q <= 1'b0;
         cnt_en <= 1'b0;
         ie_q   <= '0;
      end else if (reg_we) begin
         if (hit(reg_addr, A_CEIL)) ceil_q <= reg_wdata;
         if (hit(reg_addr, A_DEC)) begin
            src_q  <= src_e'(reg_wdata[B_SRC_HI:B_SRC_LO]);
            both_q <= reg_wdata[B_BOTH];
         end
         if (hit(reg_addr, A_MAIN)) cnt_en <= reg_wdata[B_RUN];
         if (hit(reg_addr, A_IE)) begin
            ie_q[F_OVF] <= reg_wdata[B_OVF];
            ie_q[F_UNF] <= reg_wdata[B_UNF];
         end
      end
   end

   assign clr_glb           = reg_we && hit(reg_addr, A_CLR) && reg_wdata[B_GLB];
   assign clr_ovf           = reg_we && hit(reg_addr, A_CLR) && reg_wdata[B_OVF];
   assign flag_clr[F_OVF]   = clr_ovf;
   assign flag_clr[F_UNF]   = reg_we && hit(reg_addr, A_CLR) && reg_wdata[B_UNF];
   assign flag_set[F_OVF]   = ovf_evt;
   assign flag_set[F_UNF]   = unf_evt;

   qenc_flags #(.NF(N_FLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
      .ie(ie_q), .clr_glb(clr_glb), .flags(flag_q), .glob(glob)
   );

   assign ovf_flag = flag_q[F_OVF];
   assign unf_flag = flag_q[F_UNF];
   assign ovf_ie   = ie_q[F_OVF];
   assign irq_o    = glob;

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, A_POS)) reg_rdata = pos_q;
      else if (hit(reg_addr, A_CEIL)) reg_rdata = ceil_q;
      else if (hit(reg_addr, A_DEC)) begin
         reg_rdata[B_SRC_HI:B_SRC_LO] = src_q;
         reg_rdata[B_BOTH]            = both_q;
      end else if (hit(reg_addr, A_MAIN)) reg_rdata[B_RUN] = cnt_en;
      else if (hit(reg_addr, A_IE)) begin
         reg_rdata[B_OVF] = ie_q[F_OVF];
         reg_rdata[B_UNF] = ie_q[F_UNF];
      end else if (hit(reg_addr, A_FLAG)) begin
         reg_rdata[B_OVF] = ovf_flag;
         reg_rdata[B_UNF] = unf_flag;
         reg_rdata[B_GLB] = glob;
      end
   end

endmodule

// File: rtl/qenc_poscnt_chk.sv
module qenc_poscnt_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_up,
   input logic             step_dn,
   input logic             cnt_en,
   input logic             ld_pos,
   input logic [CNT_W-1:0] pos_q,
   input logic [CNT_W-1:0] ceil_q,
   input logic             ovf_flag,
   input logic             unf_flag,
   input logic             ovf_ie,
   input logic             clr_ovf,
   input logic             clr_glb,
   input logic             irq_o
);

   p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step_up, step_dn}));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !ld_pos) |=> $stable(pos_q));

   p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && step_up && !ld_pos && pos_q >= ceil_q) |=> (pos_q == '0 && ovf_flag));

   p_wrap_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && step_dn && !ld_pos && pos_q == '0) |=> (pos_q == $past(ceil_q) && unf_flag));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf) |=> ovf_flag);

   p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && ovf_ie && !clr_ovf && !clr_glb) |=> irq_o);

   p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_glb) |=> irq_o);

endmodule

bind qenc_poscnt qenc_poscnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
   .cnt_en(cnt_en), .ld_pos(ld_pos), .pos_q(pos_q), .ceil_q(ceil_q),
   .ovf_flag(ovf_flag), .unf_flag(unf_flag), .ovf_ie(ovf_ie),
   .clr_ovf(clr_ovf), .clr_glb(clr_glb), .irq_o(irq_o)
);

// File: tb/tb_qenc_poscnt.sv
module tb_qenc_poscnt;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enc_a = 1'b0, enc_b = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qenc_poscnt dut (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input int adr, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(adr); reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int adr, output logic [31:0] v);
      @(negedge clk);
      reg_addr = 3'(adr);
      #1 v = reg_rdata;
   endtask

   // set lines, then wait until the step has landed
   task automatic lines(input logic a, input logic b);
      @(negedge clk);
      enc_a = a; enc_b = b;
      repeat (3) @(negedge clk);
   endtask

   task automatic pos_is(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      rd(0, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(0, v); chk("R1 position", v, 32'h0);
      rd(1, v); chk("R1 ceiling", v, 32'hFFFF_FFFF);
      rd(2, v); chk("R1 decoder ctl", v, 32'h0);
      rd(3, v); chk("R1 main ctl", v, 32'h0);
      rd(4, v); chk("R1 int enable", v, 32'h0);
      rd(5, v); chk("R1 flags", v, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(1, 32'd100); rd(1, v); chk("R9 ceiling readback", v, 32'd100);
      wr(0, 32'd10);  rd(0, v); chk("R9 position readback", v, 32'd10);
      wr(2, 32'h0000_0000);
      wr(3, 32'h0000_0008); rd(3, v); chk("R6 enable readback", v, 32'h8);
   endtask

   task automatic t_latency;
      @(negedge clk); reg_addr = 3'd0;
      enc_a = 1'b1;                          // 00 -> 10
      @(negedge clk); @(negedge clk);
      #1 chk("R12 not before third edge", reg_rdata, 32'd10);
      @(negedge clk);
      #1 chk("R12 on third edge", reg_rdata, 32'd11);
   endtask

   task automatic t_quad;
      lines(1, 1); pos_is("R2 fwd 10->11", 32'd12);
      lines(0, 1); pos_is("R2 fwd 11->01", 32'd13);
      lines(0, 0); pos_is("R2 fwd 01->00", 32'd14);
      lines(0, 1); pos_is("R2 rev 00->01", 32'd13);
      lines(1, 1); pos_is("R2 rev 01->11", 32'd12);
      lines(1, 0); pos_is("R2 rev 11->10", 32'd11);
      lines(0, 0); pos_is("R2 rev 10->00", 32'd10);
   endtask

   task automatic t_illegal;
      lines(1, 1); pos_is("R3 joint rise ignored", 32'd10);
      lines(0, 0); pos_is("R3 joint fall ignored", 32'd10);
   endtask

   task automatic t_pdir;
      wr(2, 32'h0000_4000);
      lines(0, 1); pos_is("R4 B edge ignored", 32'd10);
      lines(1, 1); pos_is("R4 A rise B high up", 32'd11);
      lines(0, 1); pos_is("R4 A fall ignored", 32'd11);
      lines(0, 0);
      lines(1, 0); pos_is("R4 A rise B low down", 32'd10);
      lines(0, 0);
   endtask

   task automatic t_updown;
      wr(2, 32'h0000_8000);
      lines(1, 0); pos_is("R5 up rise", 32'd11);
      lines(0, 0); pos_is("R5 up fall ignored", 32'd11);
      lines(0, 1); pos_is("R5 B ignored", 32'd11);
      wr(2, 32'h0000_8800);
      lines(1, 1); lines(0, 0); pos_is("R5 up both edges", 32'd13);
      wr(2, 32'h0000_C000);
      lines(1, 0); lines(0, 0); pos_is("R5 down rise only", 32'd12);
   endtask

   task automatic t_enable;
      wr(3, 32'h0);
      lines(1, 0); lines(0, 0); pos_is("R6 held while disabled", 32'd12);
      wr(3, 32'h8);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(4, 32'h0); wr(1, 32'd5); wr(0, 32'd5);
      wr(2, 32'h0000_8000);
      lines(1, 0); lines(0, 0);
      pos_is("R7 wrap to zero", 32'd0);
      rd(5, v); chk("R7 overflow flag", v, 32'h40);
      chk("R11 masked no irq", {31'b0, irq_o}, 32'h0);
      wr(2, 32'h0000_C000);
      lines(1, 0); lines(0, 0);
      pos_is("R8 wrap to ceiling", 32'd5);
      rd(5, v); chk("R8 underflow flag", v, 32'h60);
      wr(4, 32'h40);
      rd(5, v); chk("R11 global flag", v, 32'h61);
      chk("R11 irq raised", {31'b0, irq_o}, 32'h1);
      wr(6, 32'h40);
      rd(5, v); chk("R10 clear overflow only", v, 32'h21);
      chk("R11 irq stays without bit0 clear", {31'b0, irq_o}, 32'h1);
      wr(6, 32'h21);
      rd(5, v); chk("R10 clear all", v, 32'h0);
      chk("R11 irq cleared", {31'b0, irq_o}, 32'h0);
   endtask

   // step and register write land on the same rising edge
   task automatic t_collide;
      logic [31:0] v;
      wr(4, 32'h0);
      wr(2, 32'h0000_8000); wr(0, 32'd5);
      lines(1, 0); lines(0, 0);            // overflow flag now set, pos 0
      wr(0, 32'd5);
      @(negedge clk); enc_a = 1'b1;        // N0
      @(negedge clk);                      // N1
      @(negedge clk);                      // N2
      reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h40;
      @(negedge clk); reg_we = 1'b0;       // N3
      rd(5, v); chk("R10 event beats clear", v, 32'h40);
      pos_is("R10 wrap still applied", 32'd0);
      lines(0, 0);
      @(negedge clk); enc_a = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd42;
      @(negedge clk); reg_we = 1'b0;
      pos_is("R9 write beats step", 32'd42);
      lines(0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_latency();
      t_quad();
      t_illegal();
      t_pdir();
      t_updown();
      t_enable();
      t_wrap();
      t_collide();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule